// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the 32-bit datapath of a processor that spreads each instruction over several short clock cycles. It covers register-to-register arithmetic, OR with an immediate, word load, word store and branch-on-equal. Each step of an instruction leaves its result in a dedicated latch: the instruction latch, two operand latches, the ALU result latch and the memory data latch. The next step reads from that latch. The register file, the immediate extender, the ALU, the program counter and the branch target adder are all inside the block.

The block has no sequencer. Every latch enable, every multiplexer select and every write strobe is an input pin, and an outside state machine drives them one cycle at a time. The block returns the opcode field, the function field and a zero flag so that the state machine can choose its next step. Instruction memory and data memory are separate ports, and both are read combinationally.

Top module: `mcdp_top`

## Requirements
- R1: While `rstN` is low and after it is released, the PC, the instruction latch, the operand latches, the result latch, the memory latch and all registers are zero. So `imemAddr`, `dmemAddr`, `dmemWrData`, `opcode` and `funct` read zero.
- R2: On a clock edge with `irLoad` high, the instruction latch takes `imemData` at the current PC. `opcode` shows latch bits 31:26 and `funct` shows bits 5:0. With `irLoad` low the latch holds.
- R3: Latch A loads the register addressed by instruction bits 25:21 when `aLoad` is high. Latch B loads the register addressed by bits 20:16 when `bLoad` is high. Each latch holds when its enable is low. Register 0 always reads zero, and writes to it are discarded.
- R4: `aluSel` picks the ALU operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than, and any other value adds. When `aluFromFunct` is high, the operation comes from the function field instead: 0x20/0x21 add, 0x22/0x23 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than, anything else add. `rLoad` captures the ALU output into the result latch.
- R5: With `aluSrcImm` high, the ALU's second operand is the 16-bit immediate in bits 15:0. It is zero-extended when `immSigned` is low and sign-extended when `immSigned` is high. With `aluSrcImm` low, the second operand is latch B.
- R6: When `regWrite` is high, the write goes to the register in bits 15:11 if `dstIsRd` is high, and to the register in bits 20:16 otherwise. The data written is the memory latch if `wbFromMem` is high, otherwise the result latch. `mLoad` captures `dmemRdData` into the memory latch.
- R7: `dmemAddr` always shows the result latch and `dmemWrData` always shows latch B. `dmemWe` follows `memWrite`.
- R8: When `pcAdvance` is high, the PC grows by 4 at the edge. When `pcBranch` is high (it takes precedence), the PC becomes PC+4 plus the sign-extended immediate shifted left by 2 if `zero` is 1, and PC+4 otherwise. With neither strobe, the PC holds.
- R9: `zero` is 1 exactly when the current ALU output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| imemAddr | output | 32 | Instruction memory address (PC) |
| imemData | input | 32 | Instruction word at imemAddr |
| dmemAddr | output | 32 | Data memory address (result latch) |
| dmemWrData | output | 32 | Data memory write data (latch B) |
| dmemWe | output | 1 | Data memory write strobe |
| dmemRdData | input | 32 | Data memory read word at dmemAddr |
| irLoad | input | 1 | Instruction latch enable |
| aLoad | input | 1 | Operand latch A enable |
| bLoad | input | 1 | Operand latch B enable |
| rLoad | input | 1 | ALU result latch enable |
| mLoad | input | 1 | Memory data latch enable |
| regWrite | input | 1 | Register file write enable |
| dstIsRd | input | 1 | Destination select: 1 bits 15:11, 0 bits 20:16 |
| wbFromMem | input | 1 | Write-back source: 1 memory latch, 0 result latch |
| aluSrcImm | input | 1 | Second ALU operand: 1 immediate, 0 latch B |
| immSigned | input | 1 | Immediate extension: 1 sign, 0 zero |
| aluSel | input | 3 | Direct ALU operation code |
| aluFromFunct | input | 1 | Take ALU operation from the function field |
| memWrite | input | 1 | Data memory write request |
| pcAdvance | input | 1 | PC <= PC+4 |
| pcBranch | input | 1 | Conditional branch update of PC |
| opcode | output | 6 | Instruction latch bits 31:26 |
| funct | output | 6 | Instruction latch bits 5:0 |
| zero | output | 1 | ALU output is zero |

## Verification
Every latch, the PC and the register file change at the rising edge where their strobe is high. The bench drives the strobes at a falling edge and reads the result at the next falling edge, one cycle after the stimulus. A load's register value is therefore visible two cycles after the address step, and a register write becomes visible at the read port of a later instruction's decode cycle. `zero`, `dmemWe` and the store outputs are combinational from the latches and the selects. They are sampled one nanosecond after the selects change, before the edge that consumes them. The PC is compared at the end of every instruction against a reference model that the bench keeps.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic   irLoad;
    logic   aLoad;
    logic   bLoad;
    logic   rLoad;
    logic   mLoad;
    logic   regWrite;
    logic   dstIsRd;
    logic   wbFromMem;
    logic   srcImm;
    logic   extSign;
    logic   memWrite;
    logic   pcAdvance;
    logic   pcBranch;
    aluOp_e aluOp;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int DW = 32
) (
  input  aluOp_e          op,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  output logic [DW-1:0]   result
);

  always_comb begin
    unique case (op)
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(DW-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gReg
    if (g == 0) begin : gZero
      assign regs[g] = '0;
    end else begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                regs[g] <= '0;
        else if (wrEn && wrAddr == AW'(g))        regs[g] <= wrData;
      end
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  // R6
  wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && wrAddr == rdAddrA)
      |=> (!$stable(rdAddrA) || rdDataA == $past(wrData)));

endmodule

// File: rtl/mcdp_ctrl.sv
module mcdp_ctrl
  import mcdp_pkg::*;
(
  input  logic         irLoad,
  input  logic         aLoad,
  input  logic         bLoad,
  input  logic         rLoad,
  input  logic         mLoad,
  input  logic         regWrite,
  input  logic         dstIsRd,
  input  logic         wbFromMem,
  input  logic         aluSrcImm,
  input  logic         immSigned,
  input  logic [2:0]   aluSel,
  input  logic         aluFromFunct,
  input  logic         memWrite,
  input  logic         pcAdvance,
  input  logic         pcBranch,
  input  logic [5:0]   functField,
  output ctrlStrobes_t strobes
);

  aluOp_e directOp;
  aluOp_e functOp;

  always_comb begin
    unique case (aluSel)
      3'd1:    directOp = ALU_SUB;
      3'd2:    directOp = ALU_AND;
      3'd3:    directOp = ALU_OR;
      3'd4:    directOp = ALU_SLT;
      default: directOp = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (functField)
      6'h22, 6'h23: functOp = ALU_SUB;
      6'h24:        functOp = ALU_AND;
      6'h25:        functOp = ALU_OR;
      6'h2A:        functOp = ALU_SLT;
      default:      functOp = ALU_ADD;
    endcase
  end

  always_comb begin
    strobes.irLoad    = irLoad;
    strobes.aLoad     = aLoad;
    strobes.bLoad     = bLoad;
    strobes.rLoad     = rLoad;
    strobes.mLoad     = mLoad;
    strobes.regWrite  = regWrite;
    strobes.dstIsRd   = dstIsRd;
    strobes.wbFromMem = wbFromMem;
    strobes.srcImm    = aluSrcImm;
    strobes.extSign   = immSigned;
    strobes.memWrite  = memWrite;
    strobes.pcAdvance = pcAdvance & ~pcBranch;
    strobes.pcBranch  = pcBranch;
    strobes.aluOp     = aluFromFunct ? functOp : directOp;
  end

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int IMMW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  ctl,
  output logic [DW-1:0] imemAddr,
  input  logic [DW-1:0] imemData,
  output logic [DW-1:0] dmemAddr,
  output logic [DW-1:0] dmemWrData,
  output logic          dmemWe,
  input  logic [DW-1:0] dmemRdData,
  output logic [5:0]    opcode,
  output logic [5:0]    functField,
  output logic          zero
);

  logic [DW-1:0] pc, ir, aLat, bLat, rLat, mLat;
  logic [DW-1:0] regA, regB, immExt, immSext, aluB, aluY, wbData;
  logic [DW-1:0] seqPc, brTarget;
  logic [AW-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic [IMMW-1:0] imm;

  assign rsIdx = ir[21 +: AW];
  assign rtIdx = ir[16 +: AW];
  assign rdIdx = ir[11 +: AW];
  assign imm   = ir[IMMW-1:0];

  assign immSext = {{(DW-IMMW){imm[IMMW-1]}}, imm};
  assign immExt  = ctl.extSign ? immSext : {{(DW-IMMW){1'b0}}, imm};
  assign aluB    = ctl.srcImm ? immExt : bLat;

  mcdp_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (regA),
    .rdDataB (regB),
    .wrEn    (ctl.regWrite),
    .wrAddr  (dstIdx),
    .wrData  (wbData)
  );

  mcdp_alu #(.DW(DW)) u_alu (
    .op     (ctl.aluOp),
    .opA    (aLat),
    .opB    (aluB),
    .result (aluY)
  );

  assign zero     = (aluY == '0);
  assign dstIdx   = ctl.dstIsRd ? rdIdx : rtIdx;
  assign wbData   = ctl.wbFromMem ? mLat : rLat;
  assign seqPc    = pc + DW'(4);
  assign brTarget = seqPc + {immSext[DW-3:0], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc   <= '0;
      ir   <= '0;
      aLat <= '0;
      bLat <= '0;
      rLat <= '0;
      mLat <= '0;
    end else begin
      if (ctl.irLoad) ir   <= imemData;
      if (ctl.aLoad)  aLat <= regA;
      if (ctl.bLoad)  bLat <= regB;
      if (ctl.rLoad)  rLat <= aluY;
      if (ctl.mLoad)  mLat <= dmemRdData;
      if (ctl.pcBranch)       pc <= zero ? brTarget : seqPc;
      else if (ctl.pcAdvance) pc <= seqPc;
    end
  end

  assign imemAddr   = pc;
  assign dmemAddr   = rLat;
  assign dmemWrData = bLat;
  assign dmemWe     = ctl.memWrite;
  assign opcode     = ir[31:26];
  assign functField = ir[5:0];

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.irLoad |=> $stable(opcode) && $stable(functField));

  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.aLoad |=> $stable(aLat));

  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.bLoad |=> $stable(dmemWrData));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.pcAdvance && !ctl.pcBranch) |=> $stable(imemAddr));

  // R8
  pc_plus4_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcAdvance |=> imemAddr == $past(imemAddr) + DW'(4));

endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [DW-1:0] imemAddr,
  input  logic [DW-1:0] imemData,
  output logic [DW-1:0] dmemAddr,
  output logic [DW-1:0] dmemWrData,
  output logic          dmemWe,
  input  logic [DW-1:0] dmemRdData,
  input  logic          irLoad,
  input  logic          aLoad,
  input  logic          bLoad,
  input  logic          rLoad,
  input  logic          mLoad,
  input  logic          regWrite,
  input  logic          dstIsRd,
  input  logic          wbFromMem,
  input  logic          aluSrcImm,
  input  logic          immSigned,
  input  logic [2:0]    aluSel,
  input  logic          aluFromFunct,
  input  logic          memWrite,
  input  logic          pcAdvance,
  input  logic          pcBranch,
  output logic [5:0]    opcode,
  output logic [5:0]    funct,
  output logic          zero
);

  ctrlStrobes_t strobes;

  mcdp_ctrl u_ctrl (
    .irLoad       (irLoad),
    .aLoad        (aLoad),
    .bLoad        (bLoad),
    .rLoad        (rLoad),
    .mLoad        (mLoad),
    .regWrite     (regWrite),
    .dstIsRd      (dstIsRd),
    .wbFromMem    (wbFromMem),
    .aluSrcImm    (aluSrcImm),
    .immSigned    (immSigned),
    .aluSel       (aluSel),
    .aluFromFunct (aluFromFunct),
    .memWrite     (memWrite),
    .pcAdvance    (pcAdvance),
    .pcBranch     (pcBranch),
    .functField   (funct),
    .strobes      (strobes)
  );

  mcdp_datapath #(.DW(DW), .NREG(NREG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (strobes),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dmemAddr   (dmemAddr),
    .dmemWrData (dmemWrData),
    .dmemWe     (dmemWe),
    .dmemRdData (dmemRdData),
    .opcode     (opcode),
    .functField (funct),
    .zero       (zero)
  );

endmodule

// File: tb/sim_mcdp_top.sv
`timescale 1ns/1ps
module sim_mcdp_top;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic dmemWe;
  logic irLoad, aLoad, bLoad, rLoad, mLoad, regWrite, dstIsRd, wbFromMem;
  logic aluSrcImm, immSigned, aluFromFunct, memWrite, pcAdvance, pcBranch;
  logic [2:0] aluSel;
  logic [5:0] opcode, funct;
  logic zero;

  logic [31:0] imemArr [256];
  logic [31:0] dmemArr [256];
  logic [31:0] refReg [32];
  logic [31:0] refPc;
  logic [31:0] lastStore;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign imemData   = imemArr[imemAddr[9:2]];
  assign dmemRdData = dmemArr[dmemAddr[9:2]];
  always @(posedge clk) if (dmemWe) dmemArr[dmemAddr[9:2]] <= dmemWrData;

  mcdp_top u0 (
    .clk(clk), .rstN(rstN),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRdData(dmemRdData),
    .irLoad(irLoad), .aLoad(aLoad), .bLoad(bLoad), .rLoad(rLoad), .mLoad(mLoad),
    .regWrite(regWrite), .dstIsRd(dstIsRd), .wbFromMem(wbFromMem),
    .aluSrcImm(aluSrcImm), .immSigned(immSigned), .aluSel(aluSel),
    .aluFromFunct(aluFromFunct), .memWrite(memWrite),
    .pcAdvance(pcAdvance), .pcBranch(pcBranch),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  function automatic logic [2:0] functToOp(input logic [5:0] f);
    case (f)
      6'h22, 6'h23: return 3'd1;
      6'h24:        return 3'd2;
      6'h25:        return 3'd3;
      6'h2A:        return 3'd4;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] aluRef(input logic [2:0] op, input logic [31:0] a, b);
    case (op)
      3'd1:    return a - b;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return {31'd0, ($signed(a) < $signed(b))};
      default: return a + b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearCtl();
    irLoad = 0; aLoad = 0; bLoad = 0; rLoad = 0; mLoad = 0; regWrite = 0;
    dstIsRd = 0; wbFromMem = 0; aluSrcImm = 0; immSigned = 0; aluSel = 3'd0;
    aluFromFunct = 0; memWrite = 0; pcAdvance = 0; pcBranch = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runInstr(input logic [31:0] ins);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd, dst;
    logic [31:0] va, vb, exp, sx, wv;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sx = {{16{ins[15]}}, ins[15:0]};
    imemArr[refPc[9:2]] = ins;
    clearCtl(); irLoad = 1; tick();
    // R2: fields visible one cycle after irLoad
    chk(opcode == op && funct == ins[5:0], "R2 fields", {20'd0, opcode, funct}, {20'd0, op, ins[5:0]});
    clearCtl(); aLoad = 1; bLoad = 1; tick();
    va = refReg[rs]; vb = refReg[rt];
    clearCtl();
    exp = '0;
    case (op)
      OP_RTYPE: begin aluFromFunct = 1; rLoad = 1; exp = aluRef(functToOp(ins[5:0]), va, vb); end
      OP_ORI:   begin aluSrcImm = 1; aluSel = 3'd3; rLoad = 1; exp = va | {16'd0, ins[15:0]}; end
      OP_LW, OP_SW: begin aluSrcImm = 1; immSigned = 1; rLoad = 1; exp = va + sx; end
      default: begin
        aluSel = 3'd1; pcBranch = 1;
        #1;
        // R9
        chk(zero == (va == vb), "R9 zero flag", {31'd0, zero}, {31'd0, (va == vb)});
      end
    endcase
    tick();
    if (op == OP_BEQ) begin
      refPc = (va == vb) ? refPc + 32'd4 + {sx[29:0], 2'b00} : refPc + 32'd4;
    end else begin
      // R4 R5: result latch seen on dmemAddr
      chk(dmemAddr == exp, (op == OP_RTYPE) ? "R4 alu result" : "R5 immediate result", dmemAddr, exp);
    end
    wv = exp;
    if (op == OP_LW) begin
      clearCtl(); mLoad = 1; tick();
      wv = dmemArr[exp[9:2]];
    end
    if (op == OP_SW) begin
      clearCtl(); memWrite = 1; pcAdvance = 1; #1;
      // R7
      chk(dmemWe && dmemAddr == exp && dmemWrData == vb, "R7 store port", dmemWrData, vb);
      lastStore = dmemWrData;
      tick();
      refPc = refPc + 32'd4;
    end
    if (op == OP_RTYPE || op == OP_ORI || op == OP_LW) begin
      clearCtl(); regWrite = 1; dstIsRd = (op == OP_RTYPE); wbFromMem = (op == OP_LW);
      pcAdvance = 1; tick();
      dst = (op == OP_RTYPE) ? rd : rt;
      if (dst != 5'd0) refReg[dst] = wv;
      refPc = refPc + 32'd4;
    end
    clearCtl();
    // R8
    chk(imemAddr == refPc, "R8 pc update", imemAddr, refPc);
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [31:0] val);
    runInstr({OP_SW, 5'd0, idx, 16'h0200});
    val = lastStore;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    clearCtl();
    for (int i = 0; i < 256; i++) begin imemArr[i] = '0; dmemArr[i] = 32'h1000 + i; end
    for (int i = 0; i < 32; i++) refReg[i] = '0;
    refPc = '0;
    lastStore = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(imemAddr == 0 && dmemAddr == 0 && dmemWrData == 0, "R1 in reset", imemAddr | dmemAddr | dmemWrData, 0);
    rstN = 1'b1;
    tick();
    // R1: after release, no strobes
    chk(imemAddr == 0, "R1 pc", imemAddr, 0);
    chk(opcode == 0 && funct == 0, "R1 ir", {26'd0, opcode}, 0);
    chk(dmemAddr == 0 && dmemWrData == 0 && !dmemWe, "R1 latches", dmemAddr | dmemWrData, 0);

    runInstr({OP_ORI, 5'd0, 5'd1, 16'h00F0});
    // R2: hold with irLoad low
    imemArr[refPc[9:2]] = 32'hFFFF_FFFF;
    tick();
    chk(opcode == OP_ORI, "R2 hold", {26'd0, opcode}, {26'd0, OP_ORI});

    // R3: register 0 ignores writes
    runInstr({OP_ORI, 5'd0, 5'd0, 16'hBEEF});
    runInstr({OP_RTYPE, 5'd1, 5'd1, 5'd0, 5'd0, 6'h20});
    readReg(5'd0, v);
    chk(v == 0, "R3 reg0 zero", v, 0);

    // R6: R-type writes rd, not rt
    runInstr({OP_RTYPE, 5'd1, 5'd1, 5'd3, 5'd0, 6'h20});
    readReg(5'd3, v);
    chk(v == 32'h1E0, "R6 rd dest", v, 32'h1E0);
    readReg(5'd1, v);
    chk(v == 32'hF0, "R6 rt untouched", v, 32'hF0);

    // R6: load writes memory latch into rt
    dmemArr[64] = 32'h8000_0000;
    runInstr({OP_LW, 5'd0, 5'd5, 16'h0100});
    readReg(5'd5, v);
    chk(v == 32'h8000_0000, "R6 load value", v, 32'h8000_0000);

    // R4: signed set-less-than
    runInstr({OP_RTYPE, 5'd5, 5'd1, 5'd6, 5'd0, 6'h2A});
    readReg(5'd6, v);
    chk(v == 32'd1, "R4 slt signed", v, 1);

    // R5: zero extension for OR immediate
    runInstr({OP_ORI, 5'd5, 5'd7, 16'h8001});
    readReg(5'd7, v);
    chk(v == 32'h8000_8001, "R5 zero ext", v, 32'h8000_8001);

    // R5: negative offset load
    dmemArr[56] = 32'hCAFE_0001;
    runInstr({OP_LW, 5'd1, 5'd2, 16'hFFF0});
    readReg(5'd2, v);
    chk(v == 32'hCAFE_0001, "R5 sign ext", v, 32'hCAFE_0001);

    // R8: backward taken branch and not-taken branch
    runInstr({OP_BEQ, 5'd1, 5'd1, 16'hFFFE});
    runInstr({OP_BEQ, 5'd1, 5'd3, 16'h0010});

    for (int n = 0; n < 400; n++) begin
      logic [4:0] rs, rt, rd;
      logic [15:0] im;
      logic [5:0] fsel;
      int kind;
      rs = 5'($urandom_range(0, 7));
      rt = 5'($urandom_range(0, 7));
      rd = 5'($urandom_range(0, 7));
      im = 16'($urandom);
      kind = $urandom_range(0, 4);
      case ($urandom_range(0, 7))
        0: fsel = 6'h20; 1: fsel = 6'h21; 2: fsel = 6'h22; 3: fsel = 6'h23;
        4: fsel = 6'h24; 5: fsel = 6'h25; 6: fsel = 6'h2A; default: fsel = 6'h00;
      endcase
      case (kind)
        0: runInstr({OP_RTYPE, rs, rt, rd, 5'd0, fsel});
        1: runInstr({OP_ORI, rs, rt, im});
        2: runInstr({OP_LW, rs, rt, im});
        3: runInstr({OP_SW, rs, rt, im});
        default: runInstr({OP_BEQ, rs, rt, {{8{im[7]}}, im[7:0]}});
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule